// File: doc/BRIEF.md
# Serial Configuration Program-Verify Port

This block is the device-side end of a two-wire configuration link. It loads a 288-bit parameter set into an internal word store that stands in for nonvolatile memory. The set is made of eighteen 16-bit words and holds items such as a device serial number, a secret key and oscillator trim. One wire, `sclkIn`, acts as the shift clock. The other wire is the bidirectional data line. It is split into `sdatIn`, `sdatOut` and the enable `sdatOe`. Both inputs are asynchronous. Each passes through a synchronizer, and its edges are detected in the system clock domain, so the shift clock must run well below the system clock.

A programming session starts with an entry sequence. The host holds the clock line high for at least `SETUP_CYC` system cycles and then raises the data line. The block then clears the whole store during a timed bulk erase. After that it accepts words one at a time, least significant bit first and word 0 first. A timed write cycle follows each word. Once the last word is written, the host may read the store back once, bit by bit, on the data line. Read-back is possible only at that one moment. Any silence on the clock line longer than `TIMEOUT_CYC` returns the block to idle. Other on-chip logic reads the stored words through a plain read port.

Top module: `cfg_load_port`

## Requirements
- R1: Program mode is entered only when the synchronized data line rises while the clock line has already been high for at least `SETUP_CYC` consecutive cycles. A rise after a shorter high period leaves `busy` low and the block idle.
- R2: On entry, `busy` is high for exactly `ERASE_CYC` cycles, and every word, including any written earlier, reads as zero on `cfgRdData`.
- R3: Clock-line edges that arrive while `busy` is high are ignored. They neither shift data nor shift the word alignment.
- R4: Data is sampled on each falling clock edge. Bit n of a word is the n-th bit received (bit 0 first), and words are filled from address 0 upward. A word appears on `cfgRdData` at its address once its write cycle ends.
- R5: After the 16th bit of each word, `busy` is high for exactly `WRITE_CYC` cycles, and only then is the next word accepted.
- R6: After the write of the last word, the k-th rising clock edge (k from 1) raises `sdatOe` and puts stored bit k-1 on `sdatOut`, in programming order. The falling edge that follows the 288th bit ends verify, and `sdatOe` drops.
- R7: Verify runs once. Clock pulses after a completed verify leave `sdatOe` low.
- R8: Out of reset, with no program cycle done, clock pulses never raise `sdatOe`.
- R9: If no clock edge arrives for `TIMEOUT_CYC` cycles while loading, waiting to verify or verifying, the block returns to idle. Words already written keep their values, and a later verify attempt is refused.
- R10: `sdatOe` and `busy` are low after reset, and `sdatOe` is never high in the same cycle as `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Asynchronous serial clock line |
| sdatIn | input | 1 | Asynchronous data line, input side |
| sdatOut | output | 1 | Data line output value during verify |
| sdatOe | output | 1 | Data line output enable, high only in verify |
| busy | output | 1 | High during bulk erase and word write cycles |
| cfgRdAddr | input | $clog2(NUM_WORDS) | Word address for on-chip read of the store |
| cfgRdData | output | WORD_W | Stored word at `cfgRdAddr`, zero beyond the last word |

## Verification
Some properties are checked on every cycle. Verify can start only from the ready-to-verify state, and entry into erase only happens after the setup count is met. The store is zero the cycle after a clear. A completed word is always followed by a write cycle. No shift, write or drive strobe fires while busy, and the output enable never overlaps busy. The bench scenarios are what show the rest: the exact erase and write durations, bit and word order through a full load and read-back, the refusal of verify from reset, the second verify attempt and the attempt after a timeout, the survival of partially written words, and the handling of clock glitches injected during erase and write.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_LOAD,
    ST_WRITE,
    ST_VREADY,
    ST_VERIFY
  } ldState_e;

  // strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic clrMem;
    logic shiftIn;
    logic wrWord;
    logic drvBit;
  } dpStrobe_t;

endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut,
  output logic syncPrev
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipe     <= '0;
      syncPrev <= 1'b0;
    end else begin
      pipe     <= {pipe[STAGES-2:0], asyncIn};
      syncPrev <= pipe[STAGES-1];
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import cfg_load_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int NUM_WORDS   = 18,
  parameter int SETUP_CYC   = 16,
  parameter int ERASE_CYC   = 60,
  parameter int WRITE_CYC   = 40,
  parameter int TIMEOUT_CYC = 200,
  localparam int BW = $clog2(WORD_W),
  localparam int WW = $clog2(NUM_WORDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkS,
  input  logic          sclkP,
  input  logic          sdatS,
  input  logic          sdatP,
  output dpStrobe_t     strb,
  output logic [WW-1:0] wordIdx,
  output logic [BW-1:0] bitIdx,
  output logic          busy,
  output logic          inVerify
);

  localparam int MAX_A = (SETUP_CYC > ERASE_CYC) ? SETUP_CYC : ERASE_CYC;
  localparam int MAX_B = (WRITE_CYC > TIMEOUT_CYC) ? WRITE_CYC : TIMEOUT_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAXC + 1);

  ldState_e       state;
  logic [TW-1:0]  tmr;
  logic           sclkRise, sclkFall, sdatRise;
  logic           lastBit, lastWord, enterHit, timedOut;

  assign sclkRise = sclkS & ~sclkP;
  assign sclkFall = ~sclkS & sclkP;
  assign sdatRise = sdatS & ~sdatP;
  assign lastBit  = (bitIdx == BW'(WORD_W - 1));
  assign lastWord = (wordIdx == WW'(NUM_WORDS - 1));
  assign timedOut = (tmr == TW'(TIMEOUT_CYC - 1));
  assign enterHit = (state == ST_IDLE) && sclkS && sdatRise && (tmr >= TW'(SETUP_CYC));

  assign busy     = (state == ST_ERASE) || (state == ST_WRITE);
  assign inVerify = (state == ST_VERIFY);

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE:   strb.clrMem  = enterHit;
      ST_LOAD: begin
        strb.shiftIn = sclkFall;
        strb.wrWord  = sclkFall && lastBit;
      end
      ST_VREADY: strb.drvBit  = sclkRise;
      ST_VERIFY: strb.drvBit  = sclkRise;
      default:   strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tmr     <= '0;
      wordIdx <= '0;
      bitIdx  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (enterHit) begin
            state <= ST_ERASE;
            tmr   <= '0;
          end else if (!sclkS) begin
            tmr <= '0;
          end else if (tmr < TW'(SETUP_CYC)) begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_ERASE: begin
          if (tmr == TW'(ERASE_CYC - 1)) begin
            state   <= ST_LOAD;
            tmr     <= '0;
            wordIdx <= '0;
            bitIdx  <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_LOAD: begin
          if (sclkFall) begin
            tmr <= '0;
            if (lastBit) begin
              state  <= ST_WRITE;
              bitIdx <= '0;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else if (sclkRise) begin
            tmr <= '0;
          end else if (timedOut) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            wordIdx <= '0;
            bitIdx  <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WRITE: begin
          if (tmr == TW'(WRITE_CYC - 1)) begin
            tmr <= '0;
            if (lastWord) begin
              state   <= ST_VREADY;
              wordIdx <= '0;
            end else begin
              state   <= ST_LOAD;
              wordIdx <= wordIdx + 1'b1;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_VREADY: begin
          if (sclkRise) begin
            state <= ST_VERIFY;
            tmr   <= '0;
          end else if (timedOut) begin
            state <= ST_IDLE;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_VERIFY: begin
          if (sclkFall) begin
            tmr <= '0;
            if (lastWord && lastBit) begin
              state   <= ST_IDLE;
              wordIdx <= '0;
              bitIdx  <= '0;
            end else if (lastBit) begin
              bitIdx  <= '0;
              wordIdx <= wordIdx + 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end else if (sclkRise) begin
            tmr <= '0;
          end else if (timedOut) begin
            state   <= ST_IDLE;
            tmr     <= '0;
            wordIdx <= '0;
            bitIdx  <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          tmr   <= '0;
        end
      endcase
    end
  end

  AST_ENTRY_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASE && $past(state) == ST_IDLE) |-> ($past(tmr) >= TW'(SETUP_CYC))); // R1

  AST_NO_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.shiftIn || strb.wrWord || strb.drvBit)); // R3

  AST_WRITE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrWord |=> busy); // R5

  AST_VFY_AFTER_PROG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inVerify) |-> ($past(state) == ST_VREADY)); // R6

endmodule

// File: rtl/cfg_load_dp.sv
module cfg_load_dp
  import cfg_load_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_WORDS = 18,
  localparam int BW = $clog2(WORD_W),
  localparam int WW = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              din,
  input  logic [WW-1:0]     wordSel,
  input  logic [BW-1:0]     bitSel,
  input  logic [WW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              bitOut
);

  logic [WORD_W-1:0] store [NUM_WORDS];
  logic [WORD_W-1:0] shReg;
  logic [WORD_W-1:0] shNext;

  assign shNext = {din, shReg[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) store[i] <= '0;
      shReg  <= '0;
      bitOut <= 1'b0;
    end else begin
      if (strb.clrMem) begin
        for (int i = 0; i < NUM_WORDS; i++) store[i] <= '0;
        shReg <= '0;
      end
      if (strb.shiftIn) shReg <= shNext;
      if (strb.wrWord)  store[wordSel] <= shNext;
      if (strb.drvBit)  bitOut <= store[wordSel][bitSel];
    end
  end

  assign rdData = ({1'b0, rdAddr} < (WW + 1)'(NUM_WORDS)) ? store[rdAddr] : '0;

  AST_ERASE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMem |=> (store[0] == '0 && store[NUM_WORDS-1] == '0)); // R2

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clrMem, strb.shiftIn, strb.drvBit})); // R3

endmodule

// File: rtl/cfg_load_port.sv
module cfg_load_port
  import cfg_load_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int NUM_WORDS   = 18,
  parameter int SETUP_CYC   = 16,
  parameter int ERASE_CYC   = 60,
  parameter int WRITE_CYC   = 40,
  parameter int TIMEOUT_CYC = 200,
  parameter int SYNC_STAGES = 2,
  localparam int BW = $clog2(WORD_W),
  localparam int WW = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              sdatIn,
  output logic              sdatOut,
  output logic              sdatOe,
  output logic              busy,
  input  logic [WW-1:0]     cfgRdAddr,
  output logic [WORD_W-1:0] cfgRdData
);

  logic [1:0]    rawIn, lineS, lineP;
  dpStrobe_t     strb;
  logic [WW-1:0] wordIdx;
  logic [BW-1:0] bitIdx;
  logic          inVerify;

  assign rawIn = {sdatIn, sclkIn};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    cfg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rstN     (rstN),
      .asyncIn  (rawIn[g]),
      .syncOut  (lineS[g]),
      .syncPrev (lineP[g])
    );
  end

  cfg_load_ctrl #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SETUP_CYC(SETUP_CYC),
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkS    (lineS[0]),
    .sclkP    (lineP[0]),
    .sdatS    (lineS[1]),
    .sdatP    (lineP[1]),
    .strb     (strb),
    .wordIdx  (wordIdx),
    .bitIdx   (bitIdx),
    .busy     (busy),
    .inVerify (inVerify)
  );

  cfg_load_dp #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .din     (lineS[1]),
    .wordSel (wordIdx),
    .bitSel  (bitIdx),
    .rdAddr  (cfgRdAddr),
    .rdData  (cfgRdData),
    .bitOut  (sdatOut)
  );

  assign sdatOe = inVerify;

  AST_OE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sdatOe |-> !busy); // R10

endmodule

// File: tb/tb_cfg_load_port.sv
module tb_cfg_load_port;

  localparam int WORD_W      = 16;
  localparam int NUM_WORDS   = 18;
  localparam int SETUP_CYC   = 16;
  localparam int ERASE_CYC   = 60;
  localparam int WRITE_CYC   = 40;
  localparam int TIMEOUT_CYC = 200;
  localparam int WW          = $clog2(NUM_WORDS);
  localparam int H           = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN, sclkIn, sdatIn;
  logic              sdatOut, sdatOe, busy;
  logic [WW-1:0]     cfgRdAddr;
  logic [WORD_W-1:0] cfgRdData;

  cfg_load_port #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SETUP_CYC(SETUP_CYC),
    .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdatIn(sdatIn),
    .sdatOut(sdatOut), .sdatOe(sdatOe), .busy(busy),
    .cfgRdAddr(cfgRdAddr), .cfgRdData(cfgRdData)
  );

  int nChk = 0;
  int nBad = 0;
  int busyRun = 0;
  int lastRun = 0;
  logic [WORD_W-1:0] expMem [NUM_WORDS];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-clock monitor: busy run length and R10 overlap rule
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyRun++;
      else if (busyRun != 0) begin
        lastRun = busyRun;
        busyRun = 0;
      end
      if (sdatOe) check(!busy, "R10", "oe with busy", int'(busy), 0);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseBit(input bit b);
    sdatIn = b; idle(H);
    sclkIn = 1'b1; idle(H);
    sclkIn = 1'b0; idle(H);
  endtask

  task automatic checkMem(input string req);
    for (int w = 0; w < NUM_WORDS; w++) begin
      cfgRdAddr = WW'(w);
      #1;
      check(cfgRdData == expMem[w], req, $sformatf("word %0d", w),
            int'(cfgRdData), int'(expMem[w]));
    end
  endtask

  task automatic enter(input int hold, input bit expectIn, input bit glitch);
    sclkIn = 1'b1; sdatIn = 1'b0; idle(hold);
    sdatIn = 1'b1; idle(4);
    check(busy == expectIn, "R1", "entry busy", int'(busy), int'(expectIn));
    if (expectIn) begin
      if (glitch) begin // R3: edges during erase
        sclkIn = 1'b0; idle(4);
        sclkIn = 1'b1; idle(4);
      end
      sclkIn = 1'b0; sdatIn = 1'b0;
      while (busy) idle(1);
      idle(1);
      check(lastRun == ERASE_CYC, "R2", "erase length", lastRun, ERASE_CYC);
      for (int w = 0; w < NUM_WORDS; w++) expMem[w] = '0;
      checkMem("R2");
    end else begin
      sclkIn = 1'b0; sdatIn = 1'b0; idle(10);
      check(busy == 1'b0, "R1", "no entry", int'(busy), 0);
    end
  endtask

  task automatic sendWord(input int w, input logic [WORD_W-1:0] val, input bit glitch);
    for (int b = 0; b < WORD_W; b++) pulseBit(val[b]);
    check(busy == 1'b1, "R5", "write busy", int'(busy), 1);
    if (glitch) begin // R3: edges during write
      sdatIn = 1'b1; sclkIn = 1'b1; idle(3);
      sclkIn = 1'b0; idle(3); sdatIn = 1'b0;
    end
    while (busy) idle(1);
    idle(1);
    check(lastRun == WRITE_CYC, "R5", "write length", lastRun, WRITE_CYC);
    expMem[w] = val;
    cfgRdAddr = WW'(w);
    #1;
    check(cfgRdData == val, "R4", $sformatf("read word %0d", w), int'(cfgRdData), int'(val));
  endtask

  function automatic logic [WORD_W-1:0] pat(input int w, input int seed);
    return WORD_W'(seed * 16'h2f1b + w * 16'h9e37) ^ WORD_W'(w << 11) ^ WORD_W'(seed);
  endfunction

  task automatic programAll(input int seed, input bit glitch);
    for (int w = 0; w < NUM_WORDS; w++) sendWord(w, pat(w, seed), glitch && (w % 5 == 0));
  endtask

  task automatic verifyAll();
    for (int w = 0; w < NUM_WORDS; w++) begin
      for (int b = 0; b < WORD_W; b++) begin
        sclkIn = 1'b1; idle(H);
        check(sdatOe == 1'b1 && sdatOut == expMem[w][b], "R6",
              $sformatf("verify w%0d b%0d {oe,out}", w, b),
              int'({sdatOe, sdatOut}), int'({1'b1, expMem[w][b]}));
        sclkIn = 1'b0; idle(H);
      end
    end
    idle(H);
    check(sdatOe == 1'b0, "R6", "oe after last bit", int'(sdatOe), 0);
  endtask

  task automatic tryVerify(input string req);
    for (int i = 0; i < 5; i++) begin
      sclkIn = 1'b1; idle(H);
      check(sdatOe == 1'b0, req, "refused verify oe", int'(sdatOe), 0);
      sclkIn = 1'b0; idle(H);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    rstN = 1'b0; sclkIn = 1'b0; sdatIn = 1'b0; cfgRdAddr = '0;
    for (int w = 0; w < NUM_WORDS; w++) expMem[w] = '0;
    idle(5);
    rstN = 1'b1;
    idle(3);
    check(busy == 1'b0, "R10", "reset busy", int'(busy), 0);
    check(sdatOe == 1'b0, "R10", "reset oe", int'(sdatOe), 0);
    checkMem("R2");

    tryVerify("R8");
    enter(SETUP_CYC - 6, 1'b0, 1'b0);

    enter(SETUP_CYC + 4, 1'b1, 1'b0);
    programAll(1, 1'b0);
    verifyAll();
    tryVerify("R7");

    enter(SETUP_CYC + 4, 1'b1, 1'b1);
    for (int w = 0; w < 3; w++) sendWord(w, pat(w, 2), 1'b0);
    idle(TIMEOUT_CYC + 20);
    check(busy == 1'b0, "R9", "idle after timeout", int'(busy), 0);
    checkMem("R9");
    tryVerify("R9");

    enter(SETUP_CYC + 4, 1'b1, 1'b1);
    programAll(3, 1'b1);
    verifyAll();

    enter(SETUP_CYC + 4, 1'b1, 1'b0);
    programAll(4, 1'b0);
    idle(TIMEOUT_CYC + 20);
    tryVerify("R9");
    checkMem("R9");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule